// File: doc/BRIEF.md
# SECDED Codec for 64-bit Memory Words

This block guards a 64-bit memory word with 8 check bits, forming a 72-bit codeword that corrects any one flipped bit and detects any two. The write side is combinational. It takes the data about to be stored and returns the check field to store beside it. The read side takes a stored 72-bit word and computes the syndrome. One cycle later it presents the data, corrected if needed, with the syndrome and two strobes: one for a corrected error and one for an error it cannot correct.

The code uses a fixed syndrome value for each data bit rather than Hamming position order. A 2-bit mode input turns the code on when it equals 3. Any other value is bypass. In bypass the write side passes the currently stored check field through unchanged, so software can plant deliberate errors by rewriting only the data. Reads in bypass return the raw data and never strobe.

Top module: `ecc_sd64_codec`

## Requirements
- R1: With mode 3, `wr_chk_out[k]` (stored as codeword bit 64+k) equals the XOR of the data bits whose syndrome entry (see R5) has bit 7-k set.
- R2: With mode 0, 1 or 2, `wr_chk_out` equals `wr_chk_keep` whatever the data.
- R3: Each cycle with `rd_valid_in` high is followed, one clock edge later, by exactly one cycle of `rd_valid_out` carrying that word's results.
- R4: With mode 3, a codeword as written under R1 reads back with syndrome 0, unchanged data and both strobes low.
- R5: With mode 3, flipping data bit k alone gives entry k of this list (hex) as the syndrome: F4 F1 EC EA E9 E6 E5 E3 DC DA D9 D6 D5 D3 CE CB B5 B0 AD AB A8 A7 A4 A2 9D 9B 98 97 94 92 8F 8A 75 70 6D 6B 68 67 64 62 5E 5B 58 57 54 52 4F 4A 34 31 2C 2A 29 26 25 23 1C 1A 19 16 15 13 0E 0B. The output data is then the original word and `rd_corr` is high.
- R6: With mode 3, flipping codeword bit 64+i alone (i = 0..7) gives syndrome 8'h80 >> i, unchanged data and `rd_corr` high.
- R7: With mode 3, any two flipped bits give `rd_uncorr` high, `rd_corr` low, and the raw received data.
- R8: With mode 3, a nonzero syndrome that matches none of the 72 single-bit values is reported as `rd_uncorr`. For example, flipping codeword bits 64, 65 and 66 gives syndrome E0.
- R9: With mode 0, 1 or 2, a read returns the raw data with syndrome 0 and both strobes low, even when the word holds errors.
- R10: `rd_corr` and `rd_uncorr` are never high together, and neither is high without `rd_valid_out`.
- R11: While reset is asserted, `rd_valid_out`, `rd_corr` and `rd_uncorr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 3 = code on, other values = bypass |
| wr_data | input | 64 | Data about to be written |
| wr_chk_keep | input | 8 | Check field currently stored at the write address |
| wr_chk_out | output | 8 | Check field to store (codeword bits 71:64) |
| rd_valid_in | input | 1 | A stored word is presented |
| rd_word | input | 72 | Stored codeword, data in 63:0, check field in 71:64 |
| rd_valid_out | output | 1 | Read results valid |
| rd_data | output | 64 | Corrected or raw data |
| rd_syndrome | output | 8 | Syndrome of the word read |
| rd_corr | output | 1 | Single-bit error corrected |
| rd_uncorr | output | 1 | Error detected but not corrected |

## Verification
A wrong parity mask or a swapped check-field lane shows up as soon as the write side settles: the check field differs from the recomputed one, and clean reads then give a nonzero syndrome on the next edge. A wrong syndrome lookup entry shows up one cycle after a read with that bit flipped. Depending on the entry, it appears as a wrong syndrome, a wrong data bit, or an error classed as uncorrectable. Walking a single flip across all 72 positions reaches every lookup entry. A mode decode fault shows up either as strobes during a bypass read or as the stored check field being overwritten while the block is in bypass.

// File: rtl/ecc_sd64_pkg.sv
`timescale 1ns/1ps
package ecc_sd64_pkg;

   localparam int SD_DATA_W = 64;
   localparam int SD_PAR_W  = 8;

   // Syndrome produced when data bit k is the only bit in error.
   function automatic logic [7:0] data_syn(input int k);
      case (k)
         0:  return 8'hF4;  1: return 8'hF1;  2: return 8'hEC;  3: return 8'hEA;
         4:  return 8'hE9;  5: return 8'hE6;  6: return 8'hE5;  7: return 8'hE3;
         8:  return 8'hDC;  9: return 8'hDA; 10: return 8'hD9; 11: return 8'hD6;
         12: return 8'hD5; 13: return 8'hD3; 14: return 8'hCE; 15: return 8'hCB;
         16: return 8'hB5; 17: return 8'hB0; 18: return 8'hAD; 19: return 8'hAB;
         20: return 8'hA8; 21: return 8'hA7; 22: return 8'hA4; 23: return 8'hA2;
         24: return 8'h9D; 25: return 8'h9B; 26: return 8'h98; 27: return 8'h97;
         28: return 8'h94; 29: return 8'h92; 30: return 8'h8F; 31: return 8'h8A;
         32: return 8'h75; 33: return 8'h70; 34: return 8'h6D; 35: return 8'h6B;
         36: return 8'h68; 37: return 8'h67; 38: return 8'h64; 39: return 8'h62;
         40: return 8'h5E; 41: return 8'h5B; 42: return 8'h58; 43: return 8'h57;
         44: return 8'h54; 45: return 8'h52; 46: return 8'h4F; 47: return 8'h4A;
         48: return 8'h34; 49: return 8'h31; 50: return 8'h2C; 51: return 8'h2A;
         52: return 8'h29; 53: return 8'h26; 54: return 8'h25; 55: return 8'h23;
         56: return 8'h1C; 57: return 8'h1A; 58: return 8'h19; 59: return 8'h16;
         60: return 8'h15; 61: return 8'h13; 62: return 8'h0E; 63: return 8'h0B;
         default: return 8'h00;
      endcase
   endfunction

   // Data bits that feed parity bit j.
   function automatic logic [SD_DATA_W-1:0] par_mask(input int j);
      logic [SD_DATA_W-1:0] m;
      logic [7:0]           s;
      m = '0;
      for (int k = 0; k < SD_DATA_W; k++) begin
         s    = data_syn(k);
         m[k] = s[j];
      end
      return m;
   endfunction

endpackage

// File: rtl/ecc_sd64_parity.sv
`timescale 1ns/1ps
module ecc_sd64_parity #(
   parameter int DATA_W = ecc_sd64_pkg::SD_DATA_W,
   parameter int PAR_W  = ecc_sd64_pkg::SD_PAR_W
) (
   input  logic [DATA_W-1:0] data,
   output logic [PAR_W-1:0]  par
);

   if (DATA_W != ecc_sd64_pkg::SD_DATA_W || PAR_W != ecc_sd64_pkg::SD_PAR_W) begin : g_bad_geom
      $error("ecc_sd64_parity: syndrome table fixes the geometry at 64+8");
   end

   for (genvar j = 0; j < PAR_W; j++) begin : g_par
      localparam logic [DATA_W-1:0] MASK = ecc_sd64_pkg::par_mask(j);
      assign par[j] = ^(data & MASK);
   end

endmodule

// File: rtl/ecc_sd64_locator.sv
`timescale 1ns/1ps
module ecc_sd64_locator #(
   parameter int DATA_W = ecc_sd64_pkg::SD_DATA_W,
   parameter int PAR_W  = ecc_sd64_pkg::SD_PAR_W
) (
   input  logic [PAR_W-1:0]  syn,
   output logic [DATA_W-1:0] flip,
   output logic              corr,
   output logic              uncorr
);

   logic syn_nz;
   logic chk_hit;

   for (genvar k = 0; k < DATA_W; k++) begin : g_hit
      localparam logic [PAR_W-1:0] CODE = PAR_W'(ecc_sd64_pkg::data_syn(k));
      assign flip[k] = (syn == CODE);
   end

   assign syn_nz  = |syn;
   // A single-weight syndrome points at one check bit.
   assign chk_hit = syn_nz && ((syn & (syn - 1'b1)) == '0);
   assign corr    = (|flip) | chk_hit;
   assign uncorr  = syn_nz & ~corr;

endmodule

// File: rtl/ecc_sd64_codec.sv
`timescale 1ns/1ps
module ecc_sd64_codec #(
   parameter int         DATA_W  = ecc_sd64_pkg::SD_DATA_W,
   parameter int         PAR_W   = ecc_sd64_pkg::SD_PAR_W,
   parameter logic [1:0] MODE_ON = 2'b11
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               mode,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [PAR_W-1:0]         wr_chk_keep,
   output logic [PAR_W-1:0]         wr_chk_out,
   input  logic                     rd_valid_in,
   input  logic [DATA_W+PAR_W-1:0]  rd_word,
   output logic                     rd_valid_out,
   output logic [DATA_W-1:0]        rd_data,
   output logic [PAR_W-1:0]         rd_syndrome,
   output logic                     rd_corr,
   output logic                     rd_uncorr
);

   localparam int CW_W = DATA_W + PAR_W;

   if (DATA_W != ecc_sd64_pkg::SD_DATA_W || PAR_W != ecc_sd64_pkg::SD_PAR_W) begin : g_bad_geom
      $error("ecc_sd64_codec: only the 64+8 geometry is defined");
   end

   logic              ecc_on;
   logic [PAR_W-1:0]  wr_par, wr_field;
   logic [DATA_W-1:0] rx_data;
   logic [PAR_W-1:0]  rx_par, rx_field_par, syn;
   logic [DATA_W-1:0] flip;
   logic              loc_corr, loc_uncorr;

   assign ecc_on = (mode == MODE_ON);

   // ---------------- write side ----------------
   ecc_sd64_parity #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_wr_par (
      .data (wr_data),
      .par  (wr_par)
   );

   // Codeword bit DATA_W+k carries parity bit PAR_W-1-k.
   for (genvar k = 0; k < PAR_W; k++) begin : g_wr_lane
      assign wr_field[k] = wr_par[PAR_W-1-k];
   end

   assign wr_chk_out = ecc_on ? wr_field : wr_chk_keep;

   // ---------------- read side ----------------
   assign rx_data = rd_word[DATA_W-1:0];

   ecc_sd64_parity #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_rd_par (
      .data (rx_data),
      .par  (rx_par)
   );

   for (genvar j = 0; j < PAR_W; j++) begin : g_rd_lane
      assign rx_field_par[j] = rd_word[CW_W-1-j];
   end

   assign syn = rx_par ^ rx_field_par;

   ecc_sd64_locator #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_locate (
      .syn    (syn),
      .flip   (flip),
      .corr   (loc_corr),
      .uncorr (loc_uncorr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_out <= 1'b0;
         rd_data      <= '0;
         rd_syndrome  <= '0;
         rd_corr      <= 1'b0;
         rd_uncorr    <= 1'b0;
      end else begin
         rd_valid_out <= rd_valid_in;
         rd_data      <= (ecc_on && loc_corr) ? (rx_data ^ flip) : rx_data;
         rd_syndrome  <= ecc_on ? syn : '0;
         rd_corr      <= rd_valid_in & ecc_on & loc_corr;
         rd_uncorr    <= rd_valid_in & ecc_on & loc_uncorr;
      end
   end

   // ---------------- assertions ----------------
   AST_WR_KEEP_IN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MODE_ON) |-> (wr_chk_out == wr_chk_keep)); // R2
   AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_in |=> rd_valid_out); // R3
   AST_ZERO_SYN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_out && rd_syndrome == '0) |-> (!rd_corr && !rd_uncorr)); // R4
   AST_CORR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_corr |-> (rd_syndrome != '0)); // R5
   AST_UNCORR_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_in && ecc_on) |=> (rd_uncorr -> (rd_data == $past(rd_word[DATA_W-1:0])))); // R7
   AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid_in && !ecc_on) |=> (!rd_corr && !rd_uncorr && rd_syndrome == '0
                                    && rd_data == $past(rd_word[DATA_W-1:0]))); // R9
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_corr && rd_uncorr)); // R10
   AST_STROBE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_corr || rd_uncorr) |-> rd_valid_out); // R10

endmodule

// File: tb/ecc_sd64_codec_bench.sv
`timescale 1ns/1ps
module ecc_sd64_codec_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b11;
   logic [63:0] wr_data = '0;
   logic [7:0]  wr_chk_keep = '0;
   logic [7:0]  wr_chk_out;
   logic        rd_valid_in = 1'b0;
   logic [71:0] rd_word = '0;
   logic        rd_valid_out;
   logic [63:0] rd_data;
   logic [7:0]  rd_syndrome;
   logic        rd_corr, rd_uncorr;

   ecc_sd64_codec u_ecc_sd64_codec (
      .clk(clk), .rst_n(rst_n), .mode(mode),
      .wr_data(wr_data), .wr_chk_keep(wr_chk_keep), .wr_chk_out(wr_chk_out),
      .rd_valid_in(rd_valid_in), .rd_word(rd_word),
      .rd_valid_out(rd_valid_out), .rd_data(rd_data), .rd_syndrome(rd_syndrome),
      .rd_corr(rd_corr), .rd_uncorr(rd_uncorr)
   );

   always #10 clk = ~clk;   // 50 MHz

   int n_tests = 0;
   int n_fail  = 0;
   int n_push  = 0;
   int n_pop   = 0;
   bit done    = 1'b0;

   typedef struct {
      logic [63:0] data;
      logic [7:0]  syn;
      logic        corr;
      logic        uncorr;
      string       req;
   } exp_t;
   exp_t sb_q[$];

   // Syndrome list from R5.
   function automatic logic [7:0] spec_syn(input int k);
      logic [7:0] t [64] = '{
         8'hF4,8'hF1,8'hEC,8'hEA,8'hE9,8'hE6,8'hE5,8'hE3,8'hDC,8'hDA,8'hD9,8'hD6,8'hD5,8'hD3,8'hCE,8'hCB,
         8'hB5,8'hB0,8'hAD,8'hAB,8'hA8,8'hA7,8'hA4,8'hA2,8'h9D,8'h9B,8'h98,8'h97,8'h94,8'h92,8'h8F,8'h8A,
         8'h75,8'h70,8'h6D,8'h6B,8'h68,8'h67,8'h64,8'h62,8'h5E,8'h5B,8'h58,8'h57,8'h54,8'h52,8'h4F,8'h4A,
         8'h34,8'h31,8'h2C,8'h2A,8'h29,8'h26,8'h25,8'h23,8'h1C,8'h1A,8'h19,8'h16,8'h15,8'h13,8'h0E,8'h0B};
      return t[k];
   endfunction

   // Check field per R1.
   function automatic logic [7:0] spec_field(input logic [63:0] d);
      logic [7:0] p = '0;
      logic [7:0] f;
      for (int k = 0; k < 64; k++) if (d[k]) p ^= spec_syn(k);
      for (int k = 0; k < 8; k++) f[k] = p[7-k];
      return f;
   endfunction

   function automatic logic [71:0] spec_encode(input logic [63:0] d);
      return {spec_field(d), d};
   endfunction

   task automatic check(input bit ok, input string req, input logic [71:0] act, input logic [71:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Driver: present one word and queue what the read must produce.
   task automatic drive_read(input logic [71:0] w, input logic [1:0] m,
                             input logic [63:0] ed, input logic [7:0] es,
                             input logic ec, input logic eu, input string req);
      exp_t e;
      @(posedge clk); #2;
      e.data = ed; e.syn = es; e.corr = ec; e.uncorr = eu; e.req = req;
      sb_q.push_back(e);
      n_push++;
      mode = m; rd_word = w; rd_valid_in = 1'b1;
      @(posedge clk); #2;
      rd_valid_in = 1'b0;
   endtask

   // Monitor: compare at the falling edge after each capturing edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (!rd_valid_out && (rd_corr || rd_uncorr))
            check(1'b0, "R10 strobe without valid", {70'd0, rd_corr, rd_uncorr}, 72'd0);
         if (rd_valid_out) begin
            if (sb_q.size() == 0) begin
               check(1'b0, "R3 unexpected valid", 72'd1, 72'd0);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               n_pop++;
               check(rd_data == e.data, {e.req, " data"}, {8'd0, rd_data}, {8'd0, e.data});
               check(rd_syndrome == e.syn, {e.req, " syndrome"}, {64'd0, rd_syndrome}, {64'd0, e.syn});
               check(rd_corr == e.corr && rd_uncorr == e.uncorr, {e.req, " strobes"},
                     {70'd0, rd_corr, rd_uncorr}, {70'd0, e.corr, e.uncorr});
               check(!(rd_corr && rd_uncorr), "R10 exclusive", {70'd0, rd_corr, rd_uncorr}, 72'd0);
            end
         end
      end
   end

   initial begin
      #(20 * 100000);
      check(1'b0, "watchdog expired", 72'd0, 72'd1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] pats [4];
      logic [71:0] w;
      pats[0] = 64'h0;
      pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
      pats[2] = 64'h0101_0101_0101_0101;
      pats[3] = 64'hDEAD_BEEF_0123_4567;

      // R11: reset state
      repeat (3) @(negedge clk);
      check(!rd_valid_out && !rd_corr && !rd_uncorr, "R11 reset outputs",
            {69'd0, rd_valid_out, rd_corr, rd_uncorr}, 72'd0);
      rst_n = 1'b1;

      // R1: encode
      for (int p = 0; p < 4; p++) begin
         mode = 2'b11; wr_data = pats[p]; #1;
         check(wr_chk_out == spec_field(pats[p]), "R1 check field", {64'd0, wr_chk_out}, {64'd0, spec_field(pats[p])});
      end
      for (int k = 0; k < 64; k += 9) begin
         wr_data = 64'd1 << k; #1;
         check(wr_chk_out == spec_field(wr_data), "R1 single-bit data", {64'd0, wr_chk_out}, {64'd0, spec_field(wr_data)});
      end

      // R2: bypass keeps stored check field
      for (int m = 0; m < 3; m++) begin
         mode = 2'(m); wr_chk_keep = 8'h5A ^ 8'(m); wr_data = pats[3]; #1;
         check(wr_chk_out == wr_chk_keep, "R2 bypass write", {64'd0, wr_chk_out}, {64'd0, wr_chk_keep});
      end

      // R4: clean words
      for (int p = 0; p < 4; p++)
         drive_read(spec_encode(pats[p]), 2'b11, pats[p], 8'h00, 1'b0, 1'b0, "R4 clean");

      // R5: every single data bit
      for (int k = 0; k < 64; k++) begin
         w = spec_encode(pats[2]);
         w[k] = ~w[k];
         drive_read(w, 2'b11, pats[2], spec_syn(k), 1'b1, 1'b0, "R5 data flip");
      end

      // R6: every check bit
      for (int i = 0; i < 8; i++) begin
         w = spec_encode(pats[3]);
         w[64+i] = ~w[64+i];
         drive_read(w, 2'b11, pats[3], 8'h80 >> i, 1'b1, 1'b0, "R6 check flip");
      end

      // R7: double errors, raw data returned
      w = spec_encode(pats[2]); w[3] = ~w[3]; w[40] = ~w[40];
      drive_read(w, 2'b11, w[63:0], spec_syn(3) ^ spec_syn(40), 1'b0, 1'b1, "R7 two data bits");
      w = spec_encode(pats[3]); w[5] = ~w[5]; w[66] = ~w[66];
      drive_read(w, 2'b11, w[63:0], spec_syn(5) ^ 8'h20, 1'b0, 1'b1, "R7 data+check");
      w = spec_encode(pats[1]); w[64] = ~w[64]; w[71] = ~w[71];
      drive_read(w, 2'b11, w[63:0], 8'h81, 1'b0, 1'b1, "R7 two check bits");

      // R8: odd-weight syndrome outside the table
      w = spec_encode(pats[0]); w[64] = ~w[64]; w[65] = ~w[65]; w[66] = ~w[66];
      drive_read(w, 2'b11, w[63:0], 8'hE0, 1'b0, 1'b1, "R8 unmatched syndrome");

      // R9: bypass reads
      for (int m = 0; m < 3; m++) begin
         w = spec_encode(pats[2]); w[7] = ~w[7];
         drive_read(w, 2'(m), w[63:0], 8'h00, 1'b0, 1'b0, "R9 bypass read");
      end
      w = spec_encode(pats[3]); w[1] = ~w[1]; w[9] = ~w[9];
      drive_read(w, 2'b00, w[63:0], 8'h00, 1'b0, 1'b0, "R9 bypass double");

      repeat (3) @(posedge clk);
      @(negedge clk);
      // R3: one result per presented word
      check(sb_q.size() == 0 && n_pop == n_push, "R3 result count", 72'(n_pop), 72'(n_push));
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule